// File: doc/BRIEF.md
# Single-Bit Asynchronous SRAM Access Controller

This block lets a clocked system use an external asynchronous static memory of 1,048,576 one-bit words. The memory has only two strobes, an active-low chip enable and an active-low write enable, and no output enable. It has a dedicated one-bit input pin for write data and a separate one-bit output pin for read data. The controller takes one request at a time from a valid/ready request port. A request carries a 20-bit address, a write flag and one write bit. The controller sequences the memory strobes from counters whose lengths are derived from nanosecond minimums and the clock period. A read result comes back as a one-cycle pulse with the captured bit.

The request port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester must hold `req_valid` and the payload steady. The read response has no back-pressure: `rd_valid` is a single-cycle pulse that the consumer must take when it appears. During a write, the controller raises write enable one clock before chip enable. This makes write enable the edge that ends the write, so the data setup and hold are referenced to that edge.

Top module: `sram1_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `sram_ce_n` and `sram_we_n` are 1, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. From that edge until the controller is idle again, `req_ready` stays 0, and it is never 1 while `sram_ce_n` is 0.
- R3: For a write (`req_wr`=1), `sram_ce_n` and `sram_we_n` both fall on the accepting edge. `sram_we_n` is never 0 while `sram_ce_n` is 1.
- R4: A write ends with `sram_we_n` rising exactly one clock before `sram_ce_n` rises. The two strobes never rise on the same edge, so `sram_ce_n` stays low for one cycle more than `sram_we_n`.
- R5: `sram_addr` and `sram_din` hold the accepted request's values for every cycle in which `sram_ce_n` is 0.
- R6: For a read (`req_wr`=0), `sram_we_n` stays 1 throughout. `sram_ce_n` is low for exactly the read length. On the edge where `sram_ce_n` rises, `rd_valid` goes to 1 for exactly one cycle, and `rd_data` carries the `sram_dout` value sampled at that edge.
- R7: After `sram_ce_n` rises at the end of any access, it stays high for at least two cycles before the next access can lower it.
- R8: The write-enable low length is the largest of ceil(ns*1000/CLK_PS) over the write-pulse, chip-enable-to-end, data-setup and address-to-end minimums, and of that value for the write cycle minus one. The read length is the largest such value over access time, chip-enable access and read cycle. Each length is at least 1 cycle.
- R9: A read returns the bit most recently written to the same address, including at addresses 0 and 0xFFFFF.
- R10: `rd_valid` pulses once per read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 1 | Read result bit |
| sram_addr | output | ADDR_W | Memory address lines |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_din | output | 1 | Memory write data pin |
| sram_dout | input | 1 | Memory read data pin |

## Verification
The bench runs several kinds of traffic against a behavioural memory model that commits a bit only when an enable rises while both enables are low:
- Directed writes and reads at the lowest and highest addresses check address-line handling.
- Alternating 0 and 1 writes to a single address catch a stale or inverted capture.
- Random mixed traffic over a small address pool makes reads hit recently written bits. This separates a correct commit from a write that was dropped or cut short.
- Back-to-back requests, with `req_valid` held high, measure the strobe lengths and the enable-high gap. These distinguish a wrong counter load, a simultaneous strobe rise and a missing idle clock.

// File: rtl/sram1_pkg.sv
package sram1_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WR_ACT = 3'd1,
    ST_WR_REL = 3'd2,
    ST_RD_ACT = 3'd3,
    ST_GAP    = 3'd4
  } seq_state_t;

  // ceil(ns / period) with a floor of one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ps);
    int unsigned c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram1_timer.sv
module sram1_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

endmodule

// File: rtl/sram1_seq.sv
module sram1_seq
  import sram1_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_wr,
  input  logic tmr_done,
  output logic req_ready,
  output logic accept,
  output logic accept_wr,
  output logic we_release,
  output logic ce_release,
  output logic rd_capture
);

  seq_state_t state_q, state_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign accept_wr = accept && req_wr;

  always_comb begin
    state_d    = state_q;
    we_release = 1'b0;
    ce_release = 1'b0;
    rd_capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = req_wr ? ST_WR_ACT : ST_RD_ACT;
      end
      ST_WR_ACT: begin
        if (tmr_done) begin
          we_release = 1'b1;
          state_d    = ST_WR_REL;
        end
      end
      ST_WR_REL: begin
        ce_release = 1'b1;
        state_d    = ST_GAP;
      end
      ST_RD_ACT: begin
        if (tmr_done) begin
          ce_release = 1'b1;
          rd_capture = 1'b1;
          state_d    = ST_GAP;
        end
      end
      ST_GAP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_NO_DOUBLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    we_release |-> !ce_release); // R4
  AST_CAPTURE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (state_q == ST_RD_ACT)); // R10

endmodule

// File: rtl/sram1_pins.sv
module sram1_pins #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              accept_wr,
  input  logic              we_release,
  input  logic              ce_release,
  input  logic              rd_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              sram_dout,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_din,
  output logic              rd_valid,
  output logic              rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram_addr <= '0;
      sram_din  <= 1'b0;
    end else if (accept) begin
      sram_addr <= req_addr;
      sram_din  <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sram_ce_n <= 1'b1;
      sram_we_n <= 1'b1;
    end else begin
      if (accept)          sram_ce_n <= 1'b0;
      else if (ce_release) sram_ce_n <= 1'b1;
      if (accept_wr)       sram_we_n <= 1'b0;
      else if (we_release) sram_we_n <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= rd_capture;
      if (rd_capture) rd_data <= sram_dout;
    end
  end

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n); // R3
  AST_WE_LEADS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |-> $past(sram_we_n)); // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R5
  AST_DIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_din)); // R5
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_RDV_AT_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(sram_ce_n)); // R6
  AST_CE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |=> sram_ce_n); // R7

endmodule

// File: rtl/sram1_ctrl.sv
module sram1_ctrl
  import sram1_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned CLK_PS    = 20000,
  parameter int unsigned T_WC_NS   = 12,
  parameter int unsigned T_WP_NS   = 10,
  parameter int unsigned T_SCE_NS  = 10,
  parameter int unsigned T_SD_NS   = 7,
  parameter int unsigned T_AW_NS   = 10,
  parameter int unsigned T_RC_NS   = 12,
  parameter int unsigned T_AA_NS   = 12,
  parameter int unsigned T_ACE_NS  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rd_valid,
  output logic              rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_din,
  input  logic              sram_dout
);

  localparam int unsigned WC_M1  = (ns2cyc(T_WC_NS, CLK_PS) > 1) ? ns2cyc(T_WC_NS, CLK_PS) - 1 : 1;
  localparam int unsigned WR_CYC = umax(umax(ns2cyc(T_WP_NS, CLK_PS), ns2cyc(T_SCE_NS, CLK_PS)),
                                        umax(umax(ns2cyc(T_SD_NS, CLK_PS), ns2cyc(T_AW_NS, CLK_PS)), WC_M1));
  localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_AA_NS, CLK_PS), ns2cyc(T_ACE_NS, CLK_PS)),
                                        ns2cyc(T_RC_NS, CLK_PS));
  localparam int unsigned CNT_W  = $clog2(umax(WR_CYC, RD_CYC) + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);

  logic accept, accept_wr, we_release, ce_release, rd_capture, tmr_done;

  sram1_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_wr     (req_wr),
    .tmr_done   (tmr_done),
    .req_ready  (req_ready),
    .accept     (accept),
    .accept_wr  (accept_wr),
    .we_release (we_release),
    .ce_release (ce_release),
    .rd_capture (rd_capture)
  );

  sram1_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (req_wr ? WR_LOAD : RD_LOAD),
    .done     (tmr_done)
  );

  sram1_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .accept_wr  (accept_wr),
    .we_release (we_release),
    .ce_release (ce_release),
    .rd_capture (rd_capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .sram_dout  (sram_dout),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_din   (sram_din),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sram_ce_n); // R2
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2

endmodule

// File: tb/sim_sram1_ctrl.sv
module sim_sram1_ctrl;

  localparam int unsigned AW     = 20;
  localparam int unsigned CLK_PS = 20000;
  localparam int unsigned WP_NS  = 50;
  localparam int unsigned AA_NS  = 70;

  function automatic int unsigned cyc(input int unsigned ns);
    int unsigned c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  // expected lengths per R8: other minimums are 12/10/7 ns -> 1 cycle each
  localparam int unsigned EXP_WR = (cyc(WP_NS) > 1) ? cyc(WP_NS) : 1;
  localparam int unsigned EXP_RD = (cyc(AA_NS) > 1) ? cyc(AA_NS) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rd_valid, rd_data, sram_ce_n, sram_we_n, sram_din, sram_dout;
  logic [AW-1:0] sram_addr;

  int checks = 0, errors = 0, rdv_pulses = 0, reads_done = 0;
  bit mem [int unsigned];
  bit shadow [int unsigned];
  logic both_low_q = 1'b0;

  always #10ns clk = ~clk;

  sram1_ctrl #(.ADDR_W(AW), .CLK_PS(CLK_PS), .T_WP_NS(WP_NS), .T_AA_NS(AA_NS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_din(sram_din),
    .sram_dout(sram_dout)
  );

  // behavioural memory: commit when the both-low window closes
  always @(sram_ce_n or sram_we_n) begin
    if (both_low_q && !(!sram_ce_n && !sram_we_n)) mem[sram_addr] = sram_din;
    both_low_q = !sram_ce_n && !sram_we_n;
  end
  assign sram_dout = (!sram_ce_n && sram_we_n && mem.exists(sram_addr)) ? mem[sram_addr] : 1'b0;

  always @(posedge clk) if (rd_valid) rdv_pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expect_bit(input int unsigned a);
    return shadow.exists(a) ? shadow[a] : 1'b0;
  endfunction

  task automatic access(input bit wr, input logic [AW-1:0] a, input bit d);
    int wl = 0, cl = 0, gap_ready;
    bit we_first = 0, rdv_early = 0, we_seen_rd = 0, rdy_busy = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wr = $urandom_range(0, 1); req_addr = AW'($urandom); req_wdata = $urandom_range(0, 1);
    while (!sram_ce_n) begin
      if (!sram_we_n) wl++;
      if (sram_we_n && wr) we_first = 1;
      if (!sram_we_n && !wr) we_seen_rd = 1;
      if (rd_valid) rdv_early = 1;
      if (req_ready) rdy_busy = 1;
      if (sram_addr != a || (wr && sram_din != d)) chk(0, "R5", int'(sram_addr), int'(a));
      cl++;
      @(negedge clk);
    end
    chk(!rdy_busy, "R2", rdy_busy, 0);
    if (wr) begin
      chk(wl == EXP_WR, "R8 we_n low cycles", wl, EXP_WR);
      chk(cl == EXP_WR + 1 && we_first, "R4 ce_n low cycles", cl, EXP_WR + 1);
      chk(!rd_valid && !rdv_early, "R10", rd_valid, 0);
      shadow[a] = d;
    end else begin
      chk(!we_seen_rd, "R6 we_n during read", we_seen_rd, 0);
      chk(cl == EXP_RD, "R8 read length", cl, EXP_RD);
      chk(rd_valid && !rdv_early, "R6 rd_valid", rd_valid, 1);
      chk(rd_data == expect_bit(a), "R9 read data", rd_data, expect_bit(a));
      reads_done++;
    end
    gap_ready = req_ready;
    chk(gap_ready == 0 && sram_ce_n, "R7 gap cycle", gap_ready, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned pool [8];
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && !rd_valid, "R1 in reset", {sram_ce_n, sram_we_n, rd_valid}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && req_ready && !rd_valid, "R1 after reset",
        {sram_ce_n, sram_we_n, req_ready, rd_valid}, 4'b1110);

    // directed boundary addresses (R9)
    access(1, '0, 1);
    access(1, '1, 1);
    access(0, '0, 0);
    access(0, '1, 0);
    access(1, '1, 0);
    access(0, '1, 0);
    // alternating bit at one address (R3, R9)
    for (int i = 0; i < 6; i++) begin
      access(1, 20'h5A5A5, i[0]);
      access(0, 20'h5A5A5, 0);
    end
    // random mixed traffic over a small pool
    for (int i = 0; i < 8; i++) pool[i] = $urandom & 32'hFFFFF;
    for (int i = 0; i < 200; i++)
      access($urandom_range(0, 1), AW'(pool[$urandom_range(0, 7)]), $urandom_range(0, 1));

    repeat (3) @(negedge clk);
    chk(rdv_pulses == reads_done, "R10 pulse count", rdv_pulses, reads_done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule